// File: doc/BRIEF.md
# Variable-Latency Multiply-Accumulate Pipeline

This block multiplies two 32-bit signed source operands. It can also add the 64-bit product into a running accumulator. It works alongside the main execute pipe. An operation enters stage M1 on the clock edge that accepts `issue_i`. It then moves forward one stage per cycle. It finishes in the stage set by the effective width of the second operand (the multiplier). Each stage folds in one 8-bit slice of the multiplier. A narrow multiplier therefore finishes early, in M2, and a full-width one runs through M5.

The unit holds one operation at a time. `busy_o` tells the issuing logic to wait. While an operation sits in M1 or M2 it shares those cycles with the main pipe's first two execute stages, so a pipeline flush can still kill it. Once it reaches M3 it is committed, and it finishes whatever the flush input does. On completion the block raises a one-cycle write strobe with the destination tag and the 32-bit result for the register-file write port. In accumulate mode it also updates the accumulator, which is visible on `acc_o`.

Top module: `mac_varlat_pipe`

## Requirements
- R1: During and right after synchronous reset (`rst_n` low), `busy_o` and `wb_valid_o` are 0 and `acc_o` is 0.
- R2: The completion stage d comes from the multiplier `src_b_i`. d is 2 when the value fits in signed 8 bits (-128..127), 3 when it fits in signed 16 bits, 4 when it fits in signed 24 bits, and 5 otherwise. If the issue edge is edge 0, `wb_valid_o` is high in the cycle after edge d.
- R3: `busy_o` is high from the cycle after an accepted issue through the cycle in which the operation is in its completion stage. It is low in the strobe cycle, so a new issue can be accepted in that cycle.
- R4: `issue_i` is ignored while `busy_o` is high. The operation in flight keeps its tag, mode and operands, and no extra strobe appears.
- R5: In multiply mode (`op_mode_i` = 0), `wb_data_o` is the low 32 bits of the signed 64-bit product and `acc_o` does not change.
- R6: In accumulate mode (`op_mode_i` = 1), the accumulator becomes its old value plus the signed 64-bit product, wrapping modulo 2^64, in the strobe cycle. `wb_data_o` is the low 32 bits of the new accumulator. `acc_o` changes in no other cycle.
- R7: `wb_valid_o` is high for exactly one cycle per completed operation, with `wb_tag_o` equal to the tag given at issue.
- R8: A flush while the operation is in M1 or M2 cancels it. This holds even when M2 is its completion stage. No strobe appears, `busy_o` is low in the next cycle, and `acc_o` is unchanged.
- R9: A flush while the operation is in M3, M4 or M5 has no effect. The result is written back at the normal time with the normal value.
- R10: A flush while no operation is in flight has no effect. An issue in that same cycle is accepted and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_i | input | 1 | Request to start an operation |
| op_mode_i | input | 1 | 0 = multiply, 1 = multiply-accumulate |
| src_a_i | input | 32 | Multiplicand, signed |
| src_b_i | input | 32 | Multiplier, signed; its width sets the latency |
| dst_tag_i | input | 4 | Destination register tag |
| flush_i | input | 1 | Cancel request from the main pipe |
| busy_o | output | 1 | An operation is in flight |
| wb_valid_o | output | 1 | One-cycle write strobe |
| wb_tag_o | output | 4 | Destination tag of the written result |
| wb_data_o | output | 32 | Result value |
| acc_o | output | 64 | Accumulator contents |

## Verification
The embedded properties check the control rules on every cycle:
- stages advance one per cycle;
- a flush in M1/M2 empties the unit and suppresses the strobe;
- a flush at M3 or later leaves the operation alive;
- the strobe lasts one cycle and never overlaps `busy_o`;
- the accumulator moves only on an accumulate-mode strobe.

Only the bench scenarios can show the following:
- that the strobe lands in the cycle matching the multiplier's width class, including at the 8/16/24-bit sign boundaries;
- that the sliced product and the accumulated sum are numerically right;
- that issues arriving while busy leave the in-flight tag and result intact.

// File: rtl/mac_vl_pkg.sv
// Package: shared operation-mode type for the variable-latency MAC pipeline.
// Assumes: the mode is a single bit at the top-level port.
package mac_vl_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_MAC = 1'b1
    } mac_op_e;

endpackage

// File: rtl/mac_size_detect.sv
// Module: mac_size_detect
// Finds the stage in which a multiply can complete. A multiplier whose
// upper bits are pure sign extension of its lowest k slices needs only k
// slice steps. The result is the completion stage number (2..NSTG).
// Assumes: DATA_W is a whole multiple of CHUNK_W. Purely combinational.
module mac_size_detect #(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8,
    parameter int STG_W   = 3
) (
    input  logic [DATA_W-1:0] mult_i,
    output logic [STG_W-1:0]  done_stg_o
);
    localparam int NCH  = DATA_W / CHUNK_W;
    localparam int NSTG = NCH + 1;

    logic [NCH-1:0] fits;

    // One redundancy test per slice count: the top bits down to the sign
    // bit of slice k must all be equal.
    for (genvar k = 0; k < NCH; k++) begin : g_fit
        localparam int LO = CHUNK_W * (k + 1) - 1;
        logic [DATA_W-1-LO:0] upper;
        assign upper    = mult_i[DATA_W-1:LO];
        assign fits[k]  = (&upper) | ~(|upper);
    end

    // Pick the smallest slice count that holds the value.
    always_comb begin
        done_stg_o = STG_W'(NSTG);
        for (int k = NCH - 1; k >= 0; k--) begin
            if (fits[k]) done_stg_o = STG_W'(k + 2);
        end
    end

    // R2: completion stage always lies in M2..M(NSTG)
    always_comb begin
        a_done_range_r2: assert (done_stg_o >= STG_W'(2) && done_stg_o <= STG_W'(NSTG))
            else $error("completion stage out of range");
    end

endmodule

// File: rtl/mac_stage_tracker.sv
// Module: mac_stage_tracker
// Tracks which stage (1..NSTG, 0 = empty) the single operation in flight
// occupies. It decides when the operation finishes and when a flush kills
// it. Stages below COMMIT_STG can be killed; later ones cannot.
// Assumes: start_i is only raised while the unit is empty.
module mac_stage_tracker #(
    parameter int NSTG       = 5,
    parameter int STG_W      = 3,
    parameter int COMMIT_STG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [STG_W-1:0] done_stg_i,
    input  logic             flush_i,
    output logic [STG_W-1:0] stage_o,
    output logic [STG_W-1:0] done_o,
    output logic             busy_o,
    output logic             finish_o,
    output logic             kill_o
);
    localparam logic [STG_W-1:0] COMMIT = STG_W'(COMMIT_STG);
    localparam logic [STG_W-1:0] ONE    = STG_W'(1);
    localparam logic [STG_W-1:0] LAST   = STG_W'(NSTG);

    logic [STG_W-1:0] stage_q;
    logic [STG_W-1:0] done_q;

    // Kill only an uncommitted operation; finish one that reached its stage.
    always_comb begin
        busy_o   = (stage_q != '0);
        kill_o   = flush_i && busy_o && (stage_q < COMMIT);
        finish_o = busy_o && (stage_q == done_q) && !kill_o;
    end

    // Stage register: load on start, step each cycle, empty on finish/kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            done_q  <= '0;
        end else if (kill_o || finish_o) begin
            stage_q <= '0;
        end else if (busy_o) begin
            stage_q <= stage_q + ONE;
        end else if (start_i) begin
            stage_q <= ONE;
            done_q  <= done_stg_i;
        end
    end

    assign stage_o = stage_q;
    assign done_o  = done_q;

    // R8: a kill leaves the unit empty on the next cycle
    p_kill_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |=> (stage_q == '0));

    // R2: a live, unfinished operation moves forward exactly one stage
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish_o && !kill_o) |=> (stage_q == $past(stage_q) + ONE));

    // R2: the stage never passes the completion stage or the last stage
    p_stage_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (stage_q <= done_q && stage_q <= LAST));

    // R9: a flush at or after the commit stage leaves the operation alive
    p_commit_alive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && stage_q >= COMMIT) |-> !kill_o);

endmodule

// File: rtl/mac_mult_datapath.sv
// Module: mac_mult_datapath
// Holds the operands of the operation in flight. It folds one multiplier
// slice per stage into a 64-bit partial sum, with the final slice taken as
// signed, and on finish writes the product (multiply mode) or the updated
// accumulator (accumulate mode).
// Assumes: stage/done/finish come from mac_stage_tracker; start_i only when idle.
module mac_mult_datapath
    import mac_vl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8,
    parameter int TAG_W   = 4,
    parameter int STG_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  mac_op_e               mode_i,
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic [STG_W-1:0]      stage_i,
    input  logic [STG_W-1:0]      done_i,
    input  logic                  finish_i,
    output logic                  wb_valid_o,
    output logic [TAG_W-1:0]      wb_tag_o,
    output logic [DATA_W-1:0]     wb_data_o,
    output logic [2*DATA_W-1:0]   acc_o
);
    localparam int NCH   = DATA_W / CHUNK_W;
    localparam int ACC_W = 2 * DATA_W;
    localparam int PP_W  = DATA_W + CHUNK_W + 1;
    localparam logic [STG_W-1:0] ONE = STG_W'(1);

    mac_op_e                  mode_q;
    logic [DATA_W-1:0]        a_q;
    logic [DATA_W-1:0]        b_q;
    logic [TAG_W-1:0]         tag_q;
    logic [ACC_W-1:0]         psum_q;
    logic [ACC_W-1:0]         acc_q;
    logic [ACC_W-1:0]         acc_next;

    int                       slice_idx;
    int                       slice_base;
    logic                     last_slice;
    logic [CHUNK_W-1:0]       slice_bits;
    logic signed [CHUNK_W:0]  slice_val;
    logic signed [PP_W-1:0]   a_wide;
    logic signed [PP_W-1:0]   m_wide;
    logic signed [PP_W-1:0]   pp;
    logic signed [ACC_W-1:0]  pp_shift;

    // Select the slice for the current stage and form its shifted partial product.
    always_comb begin
        slice_idx  = (stage_i == '0) ? 0 : int'(stage_i) - 1;
        if (slice_idx > NCH - 1) slice_idx = NCH - 1;
        slice_base = slice_idx * CHUNK_W;
        slice_bits = b_q[slice_base +: CHUNK_W];
        last_slice = (stage_i == done_i - ONE);
        slice_val  = {last_slice & slice_bits[CHUNK_W-1], slice_bits};
        a_wide     = PP_W'($signed(a_q));
        m_wide     = PP_W'(slice_val);
        pp         = a_wide * m_wide;
        pp_shift   = ACC_W'(pp) <<< slice_base;
        acc_next   = acc_q + psum_q;
    end

    // Capture the operands and mode at issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OP_MUL;
            a_q    <= '0;
            b_q    <= '0;
            tag_q  <= '0;
        end else if (start_i) begin
            mode_q <= mode_i;
            a_q    <= a_i;
            b_q    <= b_i;
            tag_q  <= tag_i;
        end
    end

    // Partial sum: clear at issue, add one slice per stage before completion.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            psum_q <= '0;
        end else if (stage_i != '0 && stage_i < done_i) begin
            psum_q <= psum_q + pp_shift;
        end
    end

    // Write-back registers: one-cycle strobe with tag and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_o <= 1'b0;
            wb_tag_o   <= '0;
            wb_data_o  <= '0;
        end else begin
            wb_valid_o <= finish_i;
            if (finish_i) begin
                wb_tag_o  <= tag_q;
                wb_data_o <= (mode_q == OP_MAC) ? acc_next[DATA_W-1:0]
                                                : psum_q[DATA_W-1:0];
            end
        end
    end

    // Accumulator: updated only when an accumulate-mode operation finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (finish_i && mode_q == OP_MAC) begin
            acc_q <= acc_next;
        end
    end

    assign acc_o = acc_q;

    // R6: the accumulator never moves outside a strobe cycle
    p_acc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid_o |-> $stable(acc_q));

    // R5: a multiply-mode completion leaves the accumulator alone
    p_mul_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && mode_q == OP_MUL) |-> $stable(acc_q));

    // R7: the strobe lasts one cycle
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |=> !wb_valid_o);

endmodule

// File: rtl/mac_varlat_pipe.sv
// Module: mac_varlat_pipe (top)
// Single-operation multiply / multiply-accumulate unit with latency set by
// the multiplier width. It accepts an issue only when empty, can be killed
// by a flush during its first two stages, and writes back through a
// one-cycle strobe.
// Assumes: the issuing logic holds requests while busy_o is high.
module mac_varlat_pipe
    import mac_vl_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CHUNK_W    = 8,
    parameter int TAG_W      = 4,
    parameter int COMMIT_STG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic                op_mode_i,
    input  logic [DATA_W-1:0]   src_a_i,
    input  logic [DATA_W-1:0]   src_b_i,
    input  logic [TAG_W-1:0]    dst_tag_i,
    input  logic                flush_i,
    output logic                busy_o,
    output logic                wb_valid_o,
    output logic [TAG_W-1:0]    wb_tag_o,
    output logic [DATA_W-1:0]   wb_data_o,
    output logic [2*DATA_W-1:0] acc_o
);
    localparam int NCH   = DATA_W / CHUNK_W;
    localparam int NSTG  = NCH + 1;
    localparam int STG_W = $clog2(NSTG + 1);
    localparam logic [STG_W-1:0] COMMIT = STG_W'(COMMIT_STG);

    logic             accept;
    logic [STG_W-1:0] done_stg;
    logic [STG_W-1:0] stage;
    logic [STG_W-1:0] done_q;
    logic             finish;
    logic             kill;
    mac_op_e          mode;

    // Accept a new operation only while the unit is empty.
    always_comb begin
        accept = issue_i && !busy_o;
        mode   = mac_op_e'(op_mode_i);
    end

    mac_size_detect #(
        .DATA_W (DATA_W),
        .CHUNK_W(CHUNK_W),
        .STG_W  (STG_W)
    ) u_size (
        .mult_i    (src_b_i),
        .done_stg_o(done_stg)
    );

    mac_stage_tracker #(
        .NSTG      (NSTG),
        .STG_W     (STG_W),
        .COMMIT_STG(COMMIT_STG)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .done_stg_i(done_stg),
        .flush_i   (flush_i),
        .stage_o   (stage),
        .done_o    (done_q),
        .busy_o    (busy_o),
        .finish_o  (finish),
        .kill_o    (kill)
    );

    mac_mult_datapath #(
        .DATA_W (DATA_W),
        .CHUNK_W(CHUNK_W),
        .TAG_W  (TAG_W),
        .STG_W  (STG_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .mode_i    (mode),
        .a_i       (src_a_i),
        .b_i       (src_b_i),
        .tag_i     (dst_tag_i),
        .stage_i   (stage),
        .done_i    (done_q),
        .finish_i  (finish),
        .wb_valid_o(wb_valid_o),
        .wb_tag_o  (wb_tag_o),
        .wb_data_o (wb_data_o),
        .acc_o     (acc_o)
    );

    // R3: an accepted issue makes the unit busy on the next cycle
    p_issue_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !busy_o) |=> busy_o);

    // R3: the strobe cycle is never a busy cycle
    p_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> !busy_o);

    // R8: a flush in M1/M2 yields no strobe and an empty unit
    p_cancel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && busy_o && stage < COMMIT) |=> (!wb_valid_o && !busy_o));

    // R9: a committed operation survives a flush
    p_commit_survive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && stage >= COMMIT) |=> (busy_o || wb_valid_o));

    // R1: after reset nothing is pending
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !wb_valid_o && acc_o == '0));

    // R7: kill and finish never coincide
    p_kill_xor_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(kill && finish));

endmodule

// File: tb/sim_mac_varlat_pipe.sv
`timescale 1ns/1ps
module sim_mac_varlat_pipe;
    localparam int TAG_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue = 1'b0;
    logic             mode = 1'b0;
    logic [31:0]      a = '0;
    logic [31:0]      b = '0;
    logic [TAG_W-1:0] tag = '0;
    logic             flush = 1'b0;
    logic             busy;
    logic             wb_valid;
    logic [TAG_W-1:0] wb_tag;
    logic [31:0]      wb_data;
    logic [63:0]      acc;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] acc_m = '0;

    always #2.5 clk = ~clk;

    mac_varlat_pipe u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_mode_i(mode),
        .src_a_i(a), .src_b_i(b), .dst_tag_i(tag), .flush_i(flush),
        .busy_o(busy), .wb_valid_o(wb_valid), .wb_tag_o(wb_tag),
        .wb_data_o(wb_data), .acc_o(acc)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Completion stage from the multiplier's signed range (R2).
    function automatic int exp_stage(input logic [31:0] v);
        if ($signed(v) >= -128 && $signed(v) <= 127) return 2;
        if ($signed(v) >= -32768 && $signed(v) <= 32767) return 3;
        if ($signed(v) >= -8388608 && $signed(v) <= 8388607) return 4;
        return 5;
    endfunction

    function automatic logic [63:0] sprod(input logic [31:0] x, input logic [31:0] y);
        logic signed [63:0] sx;
        logic signed [63:0] sy;
        sx = {{32{x[31]}}, x};
        sy = {{32{y[31]}}, y};
        return sx * sy;
    endfunction

    // One operation; flush_at = cycle number (1 = M1) to raise flush, 0 = none.
    task automatic run_op(input logic [31:0] va, input logic [31:0] vb, input logic vm,
                          input logic [TAG_W-1:0] vt, input int flush_at,
                          input bit spam, input bit flush_with_issue);
        int          d;
        int          cancel_at;
        logic [63:0] prod;
        logic [63:0] acc_new;
        logic [31:0] exp_data;
        d         = exp_stage(vb);
        cancel_at = (flush_at >= 1 && flush_at <= 2 && flush_at <= d) ? flush_at : 0;
        prod      = sprod(va, vb);
        acc_new   = vm ? acc_m + prod : acc_m;
        exp_data  = vm ? acc_new[31:0] : prod[31:0];
        issue = 1'b1; a = va; b = vb; mode = vm; tag = vt; flush = flush_with_issue;
        @(negedge clk);
        issue = 1'b0; flush = 1'b0;
        for (int c = 1; c <= 7; c++) begin
            bit dead;
            dead = (cancel_at != 0) && (c > cancel_at);
            if (dead) begin
                chk(!wb_valid, "R8 no strobe after cancel", 64'(wb_valid), 0);
                chk(!busy, "R8 idle after cancel", 64'(busy), 0);
                chk(acc == acc_m, "R8 acc kept", acc, acc_m);
            end else if (c <= d) begin
                chk(busy, "R3 busy in flight", 64'(busy), 1);
                chk(!wb_valid, "R2 no early strobe", 64'(wb_valid), 0);
            end else if (c == d + 1) begin
                chk(wb_valid, "R2 strobe at completion", 64'(wb_valid), 1);
                chk(wb_tag == vt, "R7 tag / R4 tag kept", 64'(wb_tag), 64'(vt));
                chk(wb_data == exp_data, vm ? "R6 mac data" : "R5 mul data",
                    64'(wb_data), 64'(exp_data));
                chk(!busy, "R3 idle at strobe", 64'(busy), 0);
                chk(acc == acc_new, vm ? "R6 acc update" : "R5 acc unchanged", acc, acc_new);
                acc_m = acc_new;
            end else begin
                chk(!wb_valid, "R7 single strobe", 64'(wb_valid), 0);
            end
            flush = (flush_at == c);
            if (spam && !dead && c <= d) begin
                issue = 1'b1; a = $urandom; b = $urandom; mode = ~vm; tag = ~vt;
            end else begin
                issue = 1'b0;
            end
            @(negedge clk);
        end
        issue = 1'b0; flush = 1'b0;
    endtask

    function automatic logic [31:0] shaped(input int w, input logic [31:0] raw);
        logic signed [31:0] t;
        t = raw << (32 - w);
        return t >>> (32 - w);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!busy, "R1 reset busy", 64'(busy), 0);
        chk(!wb_valid, "R1 reset strobe", 64'(wb_valid), 0);
        chk(acc == 0, "R1 reset acc", acc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wb_valid && acc == 0, "R1 after reset", acc, 0);

        // Width-class boundaries (R2, R5)
        run_op(32'd3, 32'd5, 1'b0, 4'd1, 0, 0, 0);
        run_op(-32'sd7, 32'd127, 1'b0, 4'd2, 0, 0, 0);
        run_op(32'd1000, 32'd128, 1'b0, 4'd3, 0, 0, 0);
        run_op(32'h1234_5678, -32'sd128, 1'b0, 4'd4, 0, 0, 0);
        run_op(32'hdead_beef, -32'sd129, 1'b0, 4'd5, 0, 0, 0);
        run_op(32'd77, 32'd32767, 1'b0, 4'd6, 0, 0, 0);
        run_op(-32'sd77, -32'sd32768, 1'b0, 4'd7, 0, 0, 0);
        run_op(32'd99, 32'd32768, 1'b0, 4'd8, 0, 0, 0);
        run_op(32'h7fff_ffff, 32'h007f_ffff, 1'b0, 4'd9, 0, 0, 0);
        run_op(32'h8000_0000, 32'h0080_0000, 1'b0, 4'd10, 0, 0, 0);
        run_op(32'h7fff_ffff, 32'h7fff_ffff, 1'b0, 4'd11, 0, 0, 0);
        run_op(32'hffff_ffff, 32'hffff_ffff, 1'b0, 4'd12, 0, 0, 0);
        // Accumulation (R6)
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 4'd13, 0, 0, 0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 4'd14, 0, 0, 0);
        run_op(-32'sd5, 32'd3, 1'b1, 4'd15, 0, 0, 0);
        // Issue while busy ignored (R4)
        run_op(32'd11, 32'h4000_0000, 1'b1, 4'd1, 0, 1, 0);
        run_op(32'd11, 32'd9, 1'b0, 4'd2, 0, 1, 0);
        // Cancels in M1/M2 (R8), including an M2 completion
        run_op(32'd5, 32'h1000_0000, 1'b1, 4'd3, 1, 0, 0);
        run_op(32'd5, 32'd6, 1'b1, 4'd4, 2, 0, 0);
        run_op(32'd5, 32'h1000_0000, 1'b1, 4'd5, 2, 1, 0);
        // Committed flushes (R9)
        run_op(32'd123, 32'd300, 1'b1, 4'd6, 3, 0, 0);
        run_op(32'd123, 32'h2000_0000, 1'b1, 4'd7, 3, 0, 0);
        run_op(32'd123, 32'h2000_0000, 1'b1, 4'd8, 5, 1, 0);
        // Idle flush with issue (R10)
        run_op(32'd42, 32'd42, 1'b1, 4'd9, 0, 0, 1);
        run_op(32'd42, 32'h0100_0000, 1'b0, 4'd10, 0, 0, 1);

        for (int i = 0; i < 400; i++) begin
            int w;
            int fa;
            w  = 8 * (1 + int'($urandom % 4));
            fa = int'($urandom % 10);
            if (fa > 6) fa = 0;
            run_op($urandom, shaped(w, $urandom), 1'($urandom), TAG_W'($urandom),
                   fa, 1'($urandom), ($urandom % 5) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule